// File: doc/BRIEF.md
# SKP Rate-Match FIFO for 128b/130b Links

This block performs clock compensation between a recovered receive clock and the local clock on a 128b/130b serial link. A stream of 32-bit words crosses from the write domain to the read domain through a dual-clock FIFO. Each word carries two sideband markers. `start` marks the first word of every 130-bit block, which is where the 2-bit sync header sits. `skp` marks a word that holds one group of four SKP symbols.

A SKP ordered set arrives as one to five group words followed by one closing word. The first group word has both markers set. The closing word has neither marker set and carries the SKP END symbol and the 24-bit LFSR field. This gives the legal total lengths of 66, 98, 130, 162 and 194 bits. The 34 fixed bits (sync, END symbol, LFSR) always stay in place.

When the write side sees the FIFO almost full, it drops one group word that is not the first of its set, by holding back the write strobe. When the read side sees the FIFO almost empty, it waits until a set has begun and the closing word sits at the FIFO head. It then holds that word for one cycle and emits an extra group word in its place. Reading begins only after the FIFO has filled to a start level. After that, words leave on every read clock while data is available.

Top module: `skp_rate_match`

## Requirements
- R1: Every word with `skp`=0 (data words and closing words of ordered sets) leaves the block in write order, with unchanged data and `start` marker and with `out_skp`=0.
- R2: If the almost-full level (write-side fill >= `AF_LVL`) holds when a group word with `start`=0 arrives inside a set that has not yet been trimmed, that word is not stored. `del_pulse` is high for exactly one write clock, one cycle later.
- R3: If the almost-empty level (read-side fill <= `AE_LVL`) holds while the closing word of a set is at the head, fewer than `MAX_GRP` groups of that set have left, and the set has not yet been extended, the output carries one group word (data `SKP_WORD`, default 0xAAAAAAAA, `start`=0, `skp`=1) ahead of the closing word. `ins_pulse` is high for exactly one read clock.
- R4: Every ordered set at the output has between 1 and `MAX_GRP` (5) group words, i.e. a legal length of 66 to 194 bits. Its first group word, the one with `start`=1, is never removed.
- R5: Each ordered set is changed by at most one group in each direction on each side. An output set differs from its input set by -1, 0 or +1 groups, and -1 only when the input set had two or more groups.
- R6: The FIFO neither overflows nor underflows. After output has begun and while input keeps arriving every write cycle, `out_valid` stays high on every read clock.
- R7: While reset is held and right after it, `out_valid`, `del_pulse` and `ins_pulse` are 0.
- R8: `out_valid` stays 0 until the read side has seen at least `START_LVL` words in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word |
| in_start | input | 1 | First word of a 130-bit block |
| in_skp | input | 1 | Word is a group of four SKP symbols |
| del_pulse | output | 1 | One-cycle pulse per deleted group (write domain) |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Output word |
| out_start | output | 1 | First word of a 130-bit block |
| out_skp | output | 1 | Word is a SKP group |
| ins_pulse | output | 1 | One-cycle pulse per inserted group (read domain) |

## Verification
The bench uses the default parameters: depth 16, almost-full at 12, almost-empty at 4, start level 8 and at most 5 groups per set. A depth this shallow lets a write clock about 250 ppm fast reach the almost-full level, and then a slow clock reach the almost-empty level, each within a few tens of thousands of words. Both deletions and insertions therefore occur in one short run. Input sets cycle through every legal group count, so the one-group sets test the rule that protects the first group, and the five-group sets test the ceiling on insertion.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic              start;
    logic              skp;
    logic [WORD_W-1:0] data;
  } rm_word_t;
endpackage

// File: rtl/rm_ptr_sync.sv
// Two-flop synchroniser for a Gray-coded pointer, converted back to binary.
module rm_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_out[W-1] = sync_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/rm_async_fifo.sv
// Dual-clock FIFO with show-ahead head register and level flags.
module rm_async_fifo
  import rm_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int AF_LVL    = DEPTH - 4,
  parameter int AE_LVL    = 4,
  parameter int START_LVL = DEPTH / 2
) (
  input  logic     wr_clk,
  input  logic     wr_rst,
  input  logic     wr_en,
  input  rm_word_t wr_word,
  output logic     afull,
  input  logic     rd_clk,
  input  logic     rd_rst,
  input  logic     consume,
  output rm_word_t head,
  output logic     head_vld,
  output logic     aempty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  rm_word_t mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wbin_nxt, wgray, rbin_w, wlevel;
  logic          full, push;

  assign wlevel   = wbin - rbin_w;
  assign full     = (wlevel == PW'(DEPTH));
  assign afull    = (wlevel >= PW'(AF_LVL));
  assign push     = wr_en && !full;
  assign wbin_nxt = wbin + PW'(1);

  always_ff @(posedge wr_clk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_word;
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  // read domain
  logic [PW-1:0] rbin, rbin_nxt, rgray, wbin_r, rlevel;
  logic          empty, started, fetch;

  assign rlevel   = wbin_r - rbin;
  assign empty    = (rlevel == '0);
  assign aempty   = (rlevel <= PW'(AE_LVL));
  assign fetch    = started && !empty && (!head_vld || consume);
  assign rbin_nxt = rbin + PW'(1);

  always_ff @(posedge rd_clk) begin
    if (fetch) head <= mem[rbin[AW-1:0]];
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rbin     <= '0;
      rgray    <= '0;
      started  <= 1'b0;
      head_vld <= 1'b0;
    end else begin
      if (rlevel >= PW'(START_LVL)) started <= 1'b1;
      head_vld <= fetch || (head_vld && !consume);
      if (fetch) begin
        rbin  <= rbin_nxt;
        rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      end
    end
  end

  rm_ptr_sync #(.W(PW)) u_rd2wr (.clk(wr_clk), .rst(wr_rst), .gray_in(rgray), .bin_out(rbin_w));
  rm_ptr_sync #(.W(PW)) u_wr2rd (.clk(rd_clk), .rst(rd_rst), .gray_in(wgray), .bin_out(wbin_r));

  p_no_overflow_r6: assert property (@(posedge wr_clk) disable iff (wr_rst) wr_en |-> !full)
    else $error("p_no_overflow_r6");
  p_no_underflow_r6: assert property (@(posedge rd_clk) disable iff (rd_rst) consume |-> head_vld)
    else $error("p_no_underflow_r6");
  p_hold_until_fill_r8: assert property (@(posedge rd_clk) disable iff (rd_rst) !started |=> !head_vld)
    else $error("p_hold_until_fill_r8");
endmodule

// File: rtl/rm_skp_deleter.sv
// Write side: drops one non-first SKP group per ordered set when almost full.
module rm_skp_deleter (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_start,
  input  logic in_skp,
  input  logic afull,
  output logic wr_en,
  output logic del_pulse
);
  logic in_os, trimmed, del_now;

  assign del_now = in_valid && in_skp && !in_start && in_os && !trimmed && afull;
  assign wr_en   = in_valid && !del_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_os     <= 1'b0;
      trimmed   <= 1'b0;
      del_pulse <= 1'b0;
    end else begin
      del_pulse <= del_now;
      if (in_valid) begin
        if (in_start && in_skp) begin
          in_os   <= 1'b1;
          trimmed <= 1'b0;
        end else if (!in_skp) begin
          in_os   <= 1'b0;
          trimmed <= 1'b0;
        end else if (del_now) begin
          trimmed <= 1'b1;
        end
      end
    end
  end

  p_keep_first_r4: assert property (@(posedge clk) disable iff (rst) (in_valid && in_start) |-> wr_en)
    else $error("p_keep_first_r4");
  p_del_single_r5: assert property (@(posedge clk) disable iff (rst) del_pulse |=> !del_pulse)
    else $error("p_del_single_r5");
endmodule

// File: rtl/rm_skp_inserter.sv
// Read side: adds one SKP group ahead of the closing word when almost empty.
module rm_skp_inserter
  import rm_pkg::*;
#(
  parameter int              MAX_GRP  = 5,
  parameter logic [WORD_W-1:0] SKP_WORD = 32'hAAAA_AAAA
) (
  input  logic     clk,
  input  logic     rst,
  input  rm_word_t head,
  input  logic     head_vld,
  input  logic     aempty,
  output logic     consume,
  output logic     out_valid,
  output rm_word_t out_word,
  output logic     ins_pulse
);
  localparam int CW = $clog2(MAX_GRP + 2);

  logic          in_os, extended, ins_now;
  logic [CW-1:0] grp_cnt;

  assign ins_now = head_vld && in_os && !head.skp && !head.start &&
                   (grp_cnt < CW'(MAX_GRP)) && !extended && aempty;
  assign consume = head_vld && !ins_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      ins_pulse <= 1'b0;
      in_os     <= 1'b0;
      extended  <= 1'b0;
      grp_cnt   <= '0;
    end else begin
      out_valid <= head_vld;
      ins_pulse <= ins_now;
      if (ins_now) begin
        out_word <= '{start: 1'b0, skp: 1'b1, data: SKP_WORD};
        grp_cnt  <= grp_cnt + CW'(1);
        extended <= 1'b1;
      end else begin
        out_word <= head;
        if (consume) begin
          if (head.start && head.skp) begin
            in_os    <= 1'b1;
            extended <= 1'b0;
            grp_cnt  <= CW'(1);
          end else if (head.skp && in_os) begin
            grp_cnt <= grp_cnt + CW'(1);
          end else if (!head.skp) begin
            in_os <= 1'b0;
          end
        end
      end
    end
  end

  p_ins_holds_head_r3: assert property (@(posedge clk) disable iff (rst)
    ins_now |=> (head_vld && $stable(head)))
    else $error("p_ins_holds_head_r3");
  p_grp_bound_r4: assert property (@(posedge clk) disable iff (rst) grp_cnt <= CW'(MAX_GRP))
    else $error("p_grp_bound_r4");
  p_ins_single_r5: assert property (@(posedge clk) disable iff (rst) ins_pulse |=> !ins_pulse)
    else $error("p_ins_single_r5");
endmodule

// File: rtl/skp_rate_match.sv
module skp_rate_match
  import rm_pkg::*;
#(
  parameter int                DEPTH     = 16,
  parameter int                AF_LVL    = DEPTH - 4,
  parameter int                AE_LVL    = 4,
  parameter int                START_LVL = DEPTH / 2,
  parameter int                MAX_GRP   = 5,
  parameter logic [WORD_W-1:0] SKP_WORD  = 32'hAAAA_AAAA
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_start,
  input  logic              in_skp,
  output logic              del_pulse,
  input  logic              rd_clk,
  input  logic              rd_rst,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_start,
  output logic              out_skp,
  output logic              ins_pulse
);
  rm_word_t wr_word, head, out_word;
  logic     wr_en, afull, aempty, consume, head_vld;

  assign wr_word = '{start: in_start, skp: in_skp, data: in_data};

  rm_skp_deleter u_del (
    .clk(wr_clk), .rst(wr_rst), .in_valid(in_valid), .in_start(in_start), .in_skp(in_skp),
    .afull(afull), .wr_en(wr_en), .del_pulse(del_pulse)
  );

  rm_async_fifo #(
    .DEPTH(DEPTH), .AF_LVL(AF_LVL), .AE_LVL(AE_LVL), .START_LVL(START_LVL)
  ) u_fifo (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_word(wr_word), .afull(afull),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .consume(consume), .head(head), .head_vld(head_vld),
    .aempty(aempty)
  );

  rm_skp_inserter #(.MAX_GRP(MAX_GRP), .SKP_WORD(SKP_WORD)) u_ins (
    .clk(rd_clk), .rst(rd_rst), .head(head), .head_vld(head_vld), .aempty(aempty),
    .consume(consume), .out_valid(out_valid), .out_word(out_word), .ins_pulse(ins_pulse)
  );

  assign out_data  = out_word.data;
  assign out_start = out_word.start;
  assign out_skp   = out_word.skp;
endmodule

// File: tb/skp_rate_match_tb.sv
`timescale 1ns/1ps
module skp_rate_match_tb;
  localparam logic [31:0] SKP = 32'hAAAA_AAAA;

  logic        wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
  logic        in_valid = 0, in_start = 0, in_skp = 0;
  logic [31:0] in_data = 0;
  logic        del_pulse, ins_pulse, out_valid, out_start, out_skp;
  logic [31:0] out_data;

  realtime wr_half = 3.999;
  int      n_checks = 0, n_err = 0;
  logic [32:0] exp_q[$];
  int          grp_q[$];
  logic [31:0] seq = 32'h1000_0000;
  logic [23:0] lfsr = 24'h1;
  int words_sent = 0, del_cnt = 0, ins_cnt = 0, net = 0, cyc = 0;
  bit drive_done = 0, seen = 0, in_os = 0, prev_del = 0, prev_ins = 0, done = 0;
  int cnt = 0;

  always #(wr_half) wr_clk = ~wr_clk;
  always #4 rd_clk = ~rd_clk;

  skp_rate_match u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_valid(in_valid), .in_data(in_data),
    .in_start(in_start), .in_skp(in_skp), .del_pulse(del_pulse),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .out_valid(out_valid), .out_data(out_data),
    .out_start(out_start), .out_skp(out_skp), .ins_pulse(ins_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic s, input logic k);
    @(negedge wr_clk);
    in_valid = 1; in_data = d; in_start = s; in_skp = k;
    words_sent++;
  endtask

  task automatic send_data(input logic s);
    exp_q.push_back({s, seq});
    send(seq, s, 1'b0);
    seq++;
  endtask

  task automatic send_block();
    send_data(1'b1);
    for (int i = 0; i < 3; i++) send_data(1'b0);
  endtask

  task automatic send_os(input int g);
    for (int i = 0; i < g; i++) send(SKP, i == 0, 1'b1);
    grp_q.push_back(g);
    lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22]} ^ 24'h5a;
    exp_q.push_back({1'b0, 8'hE1, lfsr});
    send({8'hE1, lfsr}, 1'b0, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      in_valid = 0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // pulse monitors
  always @(negedge wr_clk) if (!wr_rst && !done) begin
    if (del_pulse) begin
      del_cnt++;
      chk(!prev_del, "R2", "del_pulse width", 2, 1);
    end
    prev_del = del_pulse;
  end

  always @(negedge rd_clk) if (!rd_rst && !done) begin
    if (ins_pulse) begin
      ins_cnt++;
      chk(!prev_ins, "R3", "ins_pulse width", 2, 1);
    end
    prev_ins = ins_pulse;
  end

  // output scoreboard
  always @(negedge rd_clk) if (!rd_rst && !done) begin
    if (out_valid) begin
      seen = 1;
      if (out_skp) begin
        chk(out_data == SKP, "R3", "group word data", out_data, SKP);
        if (out_start) begin
          chk(!in_os, "R4", "set opened twice", 1, 0);
          in_os = 1; cnt = 1;
        end else begin
          chk(in_os, "R4", "group outside a set", 0, 1);
          cnt++;
        end
      end else begin
        logic [32:0] e;
        if (exp_q.size() == 0) chk(0, "R1", "unexpected word", out_data, 0);
        else begin
          e = exp_q.pop_front();
          chk({out_start, out_data} == e, "R1", "ordered word", {out_start, out_data}, e);
        end
        if (in_os) begin
          int g, d;
          g = grp_q.pop_front();
          d = cnt - g;
          chk(cnt >= 1 && cnt <= 5, "R4", "groups per set", cnt, g);
          chk((d >= -1 && d <= 1) && (d != -1 || g >= 2), "R5", "set adjustment", cnt, g);
          net += d;
          in_os = 0;
        end
      end
    end else if (seen && !drive_done) begin
      chk(0, "R6", "output gap", 0, 1);
    end
  end

  // watchdog
  always @(posedge rd_clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      chk(0, "R6", "watchdog expired", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    int g;
    g = 1;
    repeat (6) @(negedge rd_clk);
    chk(out_valid == 0, "R7", "out_valid in reset", out_valid, 0);
    chk(del_pulse == 0, "R7", "del_pulse in reset", del_pulse, 0);
    chk(ins_pulse == 0, "R7", "ins_pulse in reset", ins_pulse, 0);
    @(negedge wr_clk) wr_rst = 0;
    @(negedge rd_clk) rd_rst = 0;
    repeat (3) @(negedge rd_clk);
    chk(out_valid == 0, "R7", "out_valid after reset", out_valid, 0);

    // R8: seven words, below the start level of eight
    send_block();
    for (int i = 0; i < 3; i++) send_data(1'b0);
    idle(30);
    @(negedge rd_clk);
    chk(out_valid == 0, "R8", "output before start level", out_valid, 0);
    send_data(1'b0);

    // fast write clock phase
    while (words_sent < 24000) begin
      send_os(g);
      g = (g % 5) + 1;
      repeat (8) send_block();
    end
    // slow write clock phase
    wr_half = 4.001;
    while (words_sent < 64000) begin
      send_os(g);
      g = (g % 5) + 1;
      repeat (8) send_block();
    end
    drive_done = 1;
    idle(1);
    idle(300);
    repeat (4) @(negedge rd_clk);
    done = 1;
    chk(exp_q.size() == 0, "R1", "words left undelivered", exp_q.size(), 0);
    chk(grp_q.size() == 0, "R4", "sets left undelivered", grp_q.size(), 0);
    chk(del_cnt > 0, "R2", "deletions occurred", del_cnt, 1);
    chk(ins_cnt > 0, "R3", "insertions occurred", ins_cnt, 1);
    chk(net == ins_cnt - del_cnt, "R5", "net group change vs pulses", net, ins_cnt - del_cnt);
    finish_run();
  end
endmodule